// File: doc/BRIEF.md
# Execute-Stage ALU with Class/Function Decode

This block is the arithmetic core of an execute stage, with the decoder that steers it. The main control supplies a 2-bit operation class, and the instruction supplies a 6-bit function field. A decoder turns these two into a 4-bit action code, which selects one of four operations on two 64-bit operands: bitwise AND, bitwise OR, add or subtract. A zero indication comes with the result, so a subtract can serve as an equality test for conditional branches.

The decode has two levels. The class alone fixes the operation for memory accesses (add) and for branch-on-equal (subtract). The function field is looked at only for register-register work. A class or function value that is not defined falls back to add and raises an illegal flag. Result, zero flag, illegal flag and action code are all registered. The block therefore has one cycle of latency, like a pipelined execute stage. Address generation for memory accesses uses the add path: the caller supplies the sign-extended offset as operand B.

Top module: `alu_ex_unit`

## Requirements
- R1: Operation class 2'b00 gives action code 4'b0010 (add), whatever the function field holds, and does not raise the illegal flag.
- R2: Operation class 2'b01 gives action code 4'b0110 (subtract, A minus B), whatever the function field holds, and does not raise the illegal flag.
- R3: Under operation class 2'b10, function 6'b100000 gives add (code 4'b0010) and function 6'b100010 gives subtract (code 4'b0110).
- R4: Under operation class 2'b10, function 6'b100100 gives bitwise AND (code 4'b0000) and function 6'b100101 gives bitwise OR (code 4'b0001).
- R5: The zero flag is 1 exactly when the 64-bit result is all zeros, so a subtract of equal operands sets it and a subtract of unequal operands clears it.
- R6: Add and subtract wrap modulo 2^64. When B holds a two's-complement sign-extended negative 12-bit offset, an add yields A minus the size of that offset.
- R7: Operation class 2'b11, or any function value other than the four listed under class 2'b10, gives action code 4'b0010, performs add, and sets the illegal flag. Every defined combination clears the illegal flag.
- R8: All outputs show the inputs sampled at the previous rising clock edge: one cycle of latency, and a new operation accepted on every cycle.
- R9: A synchronous active-high reset drives the result, zero flag, illegal flag and action code to all zeros at the next rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| op_class | input | 2 | Operation class from main control |
| funct | input | 6 | Instruction function field |
| opnd_a | input | 64 | First operand |
| opnd_b | input | 64 | Second operand (register value or sign-extended offset) |
| act_q | output | 4 | Registered action code |
| res_q | output | 64 | Registered ALU result |
| zero_q | output | 1 | Registered all-zero result flag |
| illegal_q | output | 1 | Registered undefined class/function flag |

## Verification
Two functions can coincide in one cycle: the illegal fallback and the zero flag. Both are raised together when an undefined function code arrives with operands whose fallback add sums to zero, such as 1 and all-ones. The bench checks that the flag is set, the result is zero and the code is the add code. Reset and a valid operation also meet when reset is raised while operands are still driven. That cycle is judged by requiring all-zero outputs, with the zero flag held low even though the result is zero.

// File: rtl/alu_dec_pkg.sv
package alu_dec_pkg;
   typedef enum logic [1:0] {
      CLS_MEM = 2'b00,
      CLS_BEQ = 2'b01,
      CLS_REG = 2'b10,
      CLS_RSV = 2'b11
   } op_class_e;

   typedef enum logic [3:0] {
      ACT_AND = 4'b0000,
      ACT_OR  = 4'b0001,
      ACT_ADD = 4'b0010,
      ACT_SUB = 4'b0110
   } alu_act_e;

   localparam int unsigned ACT_W = 4;
   localparam int unsigned FN_W  = 6;

   localparam logic [FN_W-1:0] FN_ADD = 6'b100000;
   localparam logic [FN_W-1:0] FN_SUB = 6'b100010;
   localparam logic [FN_W-1:0] FN_AND = 6'b100100;
   localparam logic [FN_W-1:0] FN_OR  = 6'b100101;
endpackage

// File: rtl/alu_act_decode.sv
module alu_act_decode
   import alu_dec_pkg::*;
(
   input  logic [1:0]      cls,
   input  logic [FN_W-1:0] fn,
   output alu_act_e        act,
   output logic            bad
);
   always_comb begin
      act = ACT_ADD;
      bad = 1'b0;
      unique case (op_class_e'(cls))
         CLS_MEM: act = ACT_ADD;
         CLS_BEQ: act = ACT_SUB;
         CLS_REG: begin
            unique case (fn)
               FN_ADD:  act = ACT_ADD;
               FN_SUB:  act = ACT_SUB;
               FN_AND:  act = ACT_AND;
               FN_OR:   act = ACT_OR;
               default: begin
                  act = ACT_ADD;
                  bad = 1'b1;
               end
            endcase
         end
         default: begin
            act = ACT_ADD;
            bad = 1'b1;
         end
      endcase
   end

   // R1 / R2: a fixed class never reports an illegal combination
   always_comb begin
      if (cls == 2'b00 || cls == 2'b01) begin
         a_r1_fixed_class_legal: assert (!bad);
      end
   end
endmodule

// File: rtl/alu_core.sv
module alu_core
   import alu_dec_pkg::*;
#(
   parameter int unsigned DATA_W       = 64,
   parameter bit          SHARED_ADDER = 1'b1
) (
   input  alu_act_e          act,
   input  logic [DATA_W-1:0] a,
   input  logic [DATA_W-1:0] b,
   output logic [DATA_W-1:0] y,
   output logic              is_zero
);
   localparam int unsigned PAD_W = DATA_W - 1;

   logic [DATA_W-1:0] arith;
   logic              do_sub;

   assign do_sub = (act == ACT_SUB);

   generate
      if (SHARED_ADDER) begin : g_shared
         // one carry chain: subtract as A + ~B + 1
         logic [DATA_W-1:0] b_eff;
         assign b_eff = b ^ {DATA_W{do_sub}};
         assign arith = a + b_eff + {{PAD_W{1'b0}}, do_sub};
      end else begin : g_split
         logic [DATA_W-1:0] sum_v;
         logic [DATA_W-1:0] dif_v;
         assign sum_v = a + b;
         assign dif_v = a - b;
         assign arith = do_sub ? dif_v : sum_v;
      end
   endgenerate

   always_comb begin
      unique case (act)
         ACT_AND: y = a & b;
         ACT_OR:  y = a | b;
         default: y = arith;
      endcase
   end

   assign is_zero = ~|y;
endmodule

// File: rtl/alu_ex_unit.sv
module alu_ex_unit
   import alu_dec_pkg::*;
#(
   parameter int unsigned DATA_W       = 64,
   parameter bit          SHARED_ADDER = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [1:0]        op_class,
   input  logic [5:0]        funct,
   input  logic [DATA_W-1:0] opnd_a,
   input  logic [DATA_W-1:0] opnd_b,
   output logic [3:0]        act_q,
   output logic [DATA_W-1:0] res_q,
   output logic              zero_q,
   output logic              illegal_q
);
   generate
      if (DATA_W < 8) begin : g_bad_width
         $error("alu_ex_unit: DATA_W must be at least 8");
      end
      if (ACT_W != 4 || FN_W != 6) begin : g_bad_codes
         $error("alu_ex_unit: action/function code widths are fixed at 4/6");
      end
   endgenerate

   alu_act_e          act_c;
   logic              bad_c;
   logic [DATA_W-1:0] y_c;
   logic              z_c;

   alu_act_decode i_dec (
      .cls (op_class),
      .fn  (funct),
      .act (act_c),
      .bad (bad_c)
   );

   alu_core #(
      .DATA_W       (DATA_W),
      .SHARED_ADDER (SHARED_ADDER)
   ) i_core (
      .act     (act_c),
      .a       (opnd_a),
      .b       (opnd_b),
      .y       (y_c),
      .is_zero (z_c)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         act_q     <= '0;
         res_q     <= '0;
         zero_q    <= 1'b0;
         illegal_q <= 1'b0;
      end else begin
         act_q     <= act_c;
         res_q     <= y_c;
         zero_q    <= z_c;
         illegal_q <= bad_c;
      end
   end

   // R9: reset clears every registered output
   a_r9_reset_clears: assert property (@(posedge clk)
      $past(rst) |-> (act_q == 4'b0000 && res_q == '0 && !zero_q && !illegal_q));

   // R1: memory class decodes to add
   a_r1_mem_is_add: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && $past(op_class) == 2'b00) |-> (act_q == 4'b0010 && !illegal_q));

   // R2: branch class decodes to subtract
   a_r2_beq_is_sub: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && $past(op_class) == 2'b01) |-> (act_q == 4'b0110 && !illegal_q));

   // R5: zero flag agrees with the registered result
   a_r5_zero_matches: assert property (@(posedge clk) disable iff (rst)
      !$past(rst) |-> (zero_q == (res_q == '0)));

   // R7: reserved class is flagged and falls back to add
   a_r7_rsv_flagged: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && $past(op_class) == 2'b11) |-> (illegal_q && act_q == 4'b0010));

   // R8: an add result appears one cycle after its operands
   a_r8_add_latency: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && $past(op_class) == 2'b00)
         |-> (res_q == $past(opnd_a) + $past(opnd_b)));
endmodule

// File: tb/test_alu_ex_unit.sv
module test_alu_ex_unit;
   logic        clk = 1'b0;
   logic        rst;
   logic [1:0]  op_class;
   logic [5:0]  funct;
   logic [63:0] opnd_a, opnd_b;
   logic [3:0]  act_q;
   logic [63:0] res_q;
   logic        zero_q, illegal_q;

   int n_tests = 0;
   int n_fail  = 0;
   bit finished = 1'b0;

   always #5 clk = ~clk;

   alu_ex_unit i_alu_ex_unit (
      .clk(clk), .rst(rst), .op_class(op_class), .funct(funct),
      .opnd_a(opnd_a), .opnd_b(opnd_b), .act_q(act_q), .res_q(res_q),
      .zero_q(zero_q), .illegal_q(illegal_q)
   );

   // behavioural reference: what the spec says, one operation at a time
   task automatic model(input logic [1:0] c, input logic [5:0] f,
                        input logic [63:0] a, input logic [63:0] b,
                        output logic [3:0] e_act, output logic [63:0] e_res,
                        output logic e_ill);
      string op;
      e_ill = 1'b0;
      if (c == 2'd0) op = "add";
      else if (c == 2'd1) op = "sub";
      else if (c == 2'd2 && f == 6'd32) op = "add";
      else if (c == 2'd2 && f == 6'd34) op = "sub";
      else if (c == 2'd2 && f == 6'd36) op = "and";
      else if (c == 2'd2 && f == 6'd37) op = "or";
      else begin op = "add"; e_ill = 1'b1; end
      if (op == "add")      begin e_act = 4'd2; e_res = a + b; end
      else if (op == "sub") begin e_act = 4'd6; e_res = a - b; end
      else if (op == "and") begin e_act = 4'd0; e_res = a & b; end
      else                  begin e_act = 4'd1; e_res = a | b; end
   endtask

   task automatic compare(input string tag, input logic [3:0] e_act,
                          input logic [63:0] e_res, input logic e_z, input logic e_ill);
      n_tests++;
      if (act_q !== e_act || res_q !== e_res || zero_q !== e_z || illegal_q !== e_ill) begin
         n_fail++;
         $display("FAIL %s: act=%h res=%h z=%b ill=%b expected act=%h res=%h z=%b ill=%b",
                  tag, act_q, res_q, zero_q, illegal_q, e_act, e_res, e_z, e_ill);
      end
   endtask

   // drive at the falling edge, judge just after the following rising edge
   task automatic step(input string tag, input logic [1:0] c, input logic [5:0] f,
                       input logic [63:0] a, input logic [63:0] b);
      logic [3:0] ea; logic [63:0] er; logic ei;
      @(negedge clk);
      op_class = c; funct = f; opnd_a = a; opnd_b = b;
      model(c, f, a, b, ea, er, ei);
      @(posedge clk); #1;
      compare(tag, ea, er, (er == 64'd0), ei);
   endtask

   initial begin
      rst = 1'b1; op_class = 2'd2; funct = 6'd37;
      opnd_a = 64'hFFFF_0000_1234_5678; opnd_b = 64'h1;
      repeat (3) @(posedge clk); #1;
      compare("R9 reset state", 4'd0, 64'd0, 1'b0, 1'b0);
      @(negedge clk); rst = 1'b0;

      // R1: funct content must not matter under the memory class
      step("R1 mem add f=00", 2'd0, 6'd0,  64'd1000, 64'd24);
      step("R1 mem add f=AND", 2'd0, 6'd36, 64'hF0F0, 64'h0F0F);
      // R6: negative 12-bit offset, sign-extended
      step("R6 neg offset", 2'd0, 6'd5, 64'h0000_0000_0000_1000, 64'hFFFF_FFFF_FFFF_F800);
      step("R6 wrap add", 2'd0, 6'd0, 64'hFFFF_FFFF_FFFF_FFFF, 64'd2);
      // R2 + R5: equality by subtract
      step("R2 R5 beq equal", 2'd1, 6'd32, 64'hDEAD_BEEF, 64'hDEAD_BEEF);
      step("R2 R5 beq unequal", 2'd1, 6'd36, 64'hDEAD_BEEF, 64'hDEAD_BEEE);
      step("R6 wrap sub", 2'd1, 6'd0, 64'd0, 64'd1);
      // R3
      step("R3 reg add", 2'd2, 6'd32, 64'h7FFF_FFFF_FFFF_FFFF, 64'd1);
      step("R3 reg sub", 2'd2, 6'd34, 64'd50, 64'd80);
      // R4
      step("R4 reg and", 2'd2, 6'd36, 64'hFF00_FF00_AAAA_5555, 64'h0FF0_0FF0_FFFF_0000);
      step("R4 reg or", 2'd2, 6'd37, 64'hFF00_0000_0000_0001, 64'h00FF_0000_0000_0100);
      step("R4 R5 and zero", 2'd2, 6'd36, 64'hAAAA_AAAA_AAAA_AAAA, 64'h5555_5555_5555_5555);
      // R7
      step("R7 bad funct", 2'd2, 6'd38, 64'd7, 64'd9);
      step("R7 bad funct near add", 2'd2, 6'd33, 64'd7, 64'd9);
      step("R7 rsv class", 2'd3, 6'd32, 64'd100, 64'd23);
      step("R7 R5 illegal with zero", 2'd2, 6'd0, 64'd1, 64'hFFFF_FFFF_FFFF_FFFF);
      // R8: back-to-back operations, each judged one cycle later
      for (int k = 0; k < 40; k++) begin
         logic [1:0] c; logic [5:0] f; logic [63:0] a, b;
         c = 2'(k % 4);
         f = (k % 3 == 0) ? 6'd34 : ((k % 3 == 1) ? 6'd37 : 6'd36);
         a = 64'h9E37_79B9_7F4A_7C15 * 64'(k + 1);
         b = (k % 5 == 0) ? a : (64'hC2B2_AE3D_27D4_EB4F ^ 64'(k * 977));
         step("R8 stream", c, f, a, b);
      end
      // R9: reset raised while a valid operation is driven
      @(negedge clk);
      rst = 1'b1; op_class = 2'd1; funct = 6'd0; opnd_a = 64'd5; opnd_b = 64'd5;
      @(posedge clk); #1;
      compare("R9 reset mid-run", 4'd0, 64'd0, 1'b0, 1'b0);
      @(negedge clk); rst = 1'b0;
      step("R9 after reset", 2'd2, 6'd34, 64'd9, 64'd4);

      if (!finished) begin
         finished = 1'b1;
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         n_tests++; n_fail++;
         $display("FAIL watchdog: run did not complete, actual=hung expected=done");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end
endmodule